// File: doc/BRIEF.md
# Iterative Multiply-Accumulate Sequencer

This block controls a multi-cycle integer multiplier inside an execute pipeline. When an operation is issued, it occupies the execute stage for a number of passes that depends on its class, on whether it returns a double-width result and on whether it updates condition flags. It then moves through a memory stage and a write stage. Issue is stalled by `busy` while the execute loop runs. The result words and the flags are announced by single-cycle strobes, each in the cycle its class defines.

The arithmetic covers signed halfword products, halfword accumulation into 32 or 64 bits, and 32x32 products with a 32-bit or a 64-bit result, signed or unsigned. The N and Z flags are derived from the complete result. Because a new operation can enter the execute stage while the previous one is still in the memory or write stage, each stage keeps its own copy of the result and of its schedule.

Top module: `mac_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, `busy`, `lo_vld`, `hi_vld` and `flg_vld` are all low.
- R2: Halfword classes use the signed low halves of the operands. For `op[1:0]`=0, `res_lo` is the 32-bit product. For `op[1:0]`=1, `res_lo` is the product plus `acc[31:0]`. For `op[1:0]`=1 with `long_sel`, the sign-extended product plus the full `acc` is split over `res_lo` and `res_hi`.
- R3: Word classes: `op[1:0]`=2 multiplies and `op[1:0]`=3 also adds `acc`. Without `long_sel` the result is the low 32 bits of the product plus `acc[31:0]`. With `long_sel` the result is the 64-bit product plus `acc`, where `op[2]`=1 selects signed operands and `op[2]`=0 selects unsigned operands.
- R4: An operation is accepted on a clock edge where `start` is high and `busy` is low. `busy` is then high for exactly the pass count of that operation. `start` while `busy` is high is ignored and does not change the results of the operation in flight.
- R5: Halfword multiply takes 1 pass, and `lo_vld` is high in cycle 3 after acceptance. `long_sel` and `set_flags` have no effect on it.
- R6: Halfword accumulate takes 2 passes, and `lo_vld` is high in cycle 3. With `long_sel`, `hi_vld` is also high in cycle 4.
- R7: Word operations without `long_sel` or `set_flags` take 2 passes, and `lo_vld` is high in cycle 4.
- R8: Word operations with `long_sel` and without `set_flags` take 3 passes, with `lo_vld` in cycle 4 and `hi_vld` in cycle 5.
- R9: Word operations with `set_flags` and without `long_sel` take 4 passes, with `lo_vld` in cycle 4 and `flg_vld` in cycle 5.
- R10: Word operations with both `set_flags` and `long_sel` take 5 passes, with `lo_vld` in cycle 5 and both `hi_vld` and `flg_vld` in cycle 6.
- R11: When `flg_vld` is high, `flag_n` is the top bit of the 32-bit or 64-bit result and `flag_z` is 1 exactly when all result bits are zero. `set_flags` on a halfword class produces no `flg_vld`.
- R12: When `lo_vld` is high, `res_cls` equals the `op[1:0]` of the operation that produced the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Issue request |
| op | input | 3 | Class in bits 1:0, signed-long select in bit 2 |
| set_flags | input | 1 | Request N/Z flag update |
| long_sel | input | 1 | Double-width result select |
| opa | input | DW | First operand |
| opb | input | DW | Second operand |
| acc | input | 2*DW | Accumulate operand |
| busy | output | 1 | Execute loop occupied; stalls issue |
| lo_vld | output | 1 | Low result word strobe |
| res_cls | output | 2 | Class of the low word being presented |
| res_lo | output | DW | Low result word |
| hi_vld | output | 1 | High result word strobe |
| res_hi | output | DW | High result word |
| flg_vld | output | 1 | Flags strobe |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
A wrong pass counter or a wrong stage schedule shows up as a strobe that is one or more cycles early or late. It can also show as `busy` falling at the wrong cycle. Either is visible within six cycles of acceptance, because every strobe and every `busy` level is checked cycle by cycle against the table for its class. A corrupted stage data register, or a stray load caused by an ignored `start`, changes `res_lo`, `res_hi` or the flags in the very strobe cycle of the affected operation.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;

   localparam int MAX_PASS = 5;
   localparam int PW       = $clog2(MAX_PASS + 1);

   typedef enum logic [1:0] {
      K_HMUL = 2'd0,
      K_HMAC = 2'd1,
      K_WMUL = 2'd2,
      K_WMAC = 2'd3
   } kind_t;

   // stage in which a strobe fires; value = stage index + 1
   typedef enum logic [1:0] {
      STG_NONE = 2'd0,
      STG_EX   = 2'd1,
      STG_MEM  = 2'd2,
      STG_WR   = 2'd3
   } stg_t;

   typedef struct packed {
      kind_t          kind;
      logic [PW-1:0]  passes;
      stg_t           lo;
      stg_t           hi;
      stg_t           fl;
   } sched_t;

   function automatic sched_t make_sched(kind_t k, logic lng, logic flg);
      sched_t s;
      s.kind = k;
      s.hi   = STG_NONE;
      s.fl   = STG_NONE;
      case (k)
         K_HMUL: begin
            s.passes = PW'(1);
            s.lo     = STG_WR;
         end
         K_HMAC: begin
            s.passes = PW'(2);
            s.lo     = STG_MEM;
            if (lng) s.hi = STG_WR;
         end
         default: begin
            case ({lng, flg})
               2'b00: begin s.passes = PW'(2); s.lo = STG_WR; end
               2'b01: begin s.passes = PW'(4); s.lo = STG_EX;  s.fl = STG_MEM; end
               2'b10: begin s.passes = PW'(3); s.lo = STG_MEM; s.hi = STG_WR;  end
               default: begin
                  s.passes = PW'(5);
                  s.lo     = STG_EX;
                  s.hi     = STG_MEM;
                  s.fl     = STG_MEM;
               end
            endcase
         end
      endcase
      return s;
   endfunction

endpackage

// File: rtl/mac_seq_ctl.sv
module mac_seq_ctl
   import mac_seq_pkg::*;
(
   input  logic           clk,
   input  logic           rst,
   input  logic           start,
   input  sched_t         sch_in,
   output logic           busy,
   output logic           accept,
   output logic [2:0]     stg_act,
   output sched_t [2:0]   stg_sch
);

   logic          e_act, m_act, w_act;
   logic [PW-1:0] pass_q;
   sched_t        e_s, m_s, w_s;
   logic          e_last;

   assign busy    = e_act;
   assign accept  = start && !e_act;
   assign e_last  = e_act && (pass_q == e_s.passes);
   assign stg_act = {w_act, m_act, e_last};
   assign stg_sch = {w_s, m_s, e_s};

   always_ff @(posedge clk) begin
      if (rst) begin
         e_act  <= 1'b0;
         m_act  <= 1'b0;
         w_act  <= 1'b0;
         pass_q <= '0;
         e_s    <= '0;
         m_s    <= '0;
         w_s    <= '0;
      end else begin
         m_act <= e_last;
         w_act <= m_act;
         if (accept) begin
            e_act  <= 1'b1;
            pass_q <= PW'(1);
            e_s    <= sch_in;
         end else if (e_last) begin
            e_act  <= 1'b0;
            pass_q <= '0;
         end else if (e_act) begin
            pass_q <= pass_q + 1'b1;
         end
         if (e_last) m_s <= e_s;
         if (m_act)  w_s <= m_s;
      end
   end

endmodule

// File: rtl/mac_seq_dp.sv
module mac_seq_dp
   import mac_seq_pkg::*;
#(
   parameter int DW = 32
)(
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     accept,
   input  logic [1:0]               adv,
   input  kind_t                    kind,
   input  logic                     lng,
   input  logic                     sgn,
   input  logic [DW-1:0]            opa,
   input  logic [DW-1:0]            opb,
   input  logic [2*DW-1:0]          acc,
   output logic [2:0][2*DW-1:0]     stg_res,
   output logic [2:0]               stg_n,
   output logic [2:0]               stg_z
);

   localparam int HW = DW / 2;
   localparam int RW = 2 * DW;

   logic [DW-1:0] hx_a, hx_b, hprod;
   logic [RW-1:0] wx_a, wx_b, wprod, macc, r;
   logic          fn, fz;

   always_comb begin
      hx_a  = {{HW{opa[HW-1]}}, opa[HW-1:0]};
      hx_b  = {{HW{opb[HW-1]}}, opb[HW-1:0]};
      hprod = hx_a * hx_b;
      wx_a  = sgn ? {{DW{opa[DW-1]}}, opa} : {{DW{1'b0}}, opa};
      wx_b  = sgn ? {{DW{opb[DW-1]}}, opb} : {{DW{1'b0}}, opb};
      wprod = wx_a * wx_b;
      macc  = (kind == K_WMAC) ? acc : '0;
      case (kind)
         K_HMUL: r = {{DW{1'b0}}, hprod};
         K_HMAC: r = lng ? ({{DW{hprod[DW-1]}}, hprod} + acc)
                         : {{DW{1'b0}}, hprod + acc[DW-1:0]};
         default: r = lng ? (wprod + macc)
                          : {{DW{1'b0}}, wprod[DW-1:0] + macc[DW-1:0]};
      endcase
      fn = lng ? r[RW-1] : r[DW-1];
      fz = lng ? (r == '0) : (r[DW-1:0] == '0);
   end

   // execute stage holds the result computed at issue
   always_ff @(posedge clk) begin
      if (rst) begin
         stg_res[0] <= '0;
         stg_n[0]   <= 1'b0;
         stg_z[0]   <= 1'b0;
      end else if (accept) begin
         stg_res[0] <= r;
         stg_n[0]   <= fn;
         stg_z[0]   <= fz;
      end
   end

   // memory and write stages copy from the stage before on advance
   for (genvar i = 1; i < 3; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) begin
            stg_res[i] <= '0;
            stg_n[i]   <= 1'b0;
            stg_z[i]   <= 1'b0;
         end else if (adv[i-1]) begin
            stg_res[i] <= stg_res[i-1];
            stg_n[i]   <= stg_n[i-1];
            stg_z[i]   <= stg_z[i-1];
         end
      end
   end

endmodule

// File: rtl/mac_seq_out.sv
module mac_seq_out
   import mac_seq_pkg::*;
#(
   parameter int DW = 32
)(
   input  logic [2:0]               stg_act,
   input  stg_t [2:0]               lo_stg,
   input  stg_t [2:0]               hi_stg,
   input  stg_t [2:0]               fl_stg,
   input  kind_t [2:0]              stg_kind,
   input  logic [2:0][2*DW-1:0]     stg_res,
   input  logic [2:0]               stg_n,
   input  logic [2:0]               stg_z,
   output logic                     lo_vld,
   output logic [1:0]               res_cls,
   output logic [DW-1:0]            res_lo,
   output logic                     hi_vld,
   output logic [DW-1:0]            res_hi,
   output logic                     flg_vld,
   output logic                     flag_n,
   output logic                     flag_z
);

   logic [2:0] lo_hit, hi_hit, fl_hit;

   for (genvar i = 0; i < 3; i++) begin : g_hit
      localparam stg_t CODE = stg_t'(2'(i + 1));
      assign lo_hit[i] = stg_act[i] && (lo_stg[i] == CODE);
      assign hi_hit[i] = stg_act[i] && (hi_stg[i] == CODE);
      assign fl_hit[i] = stg_act[i] && (fl_stg[i] == CODE);
   end

   assign lo_vld  = |lo_hit;
   assign hi_vld  = |hi_hit;
   assign flg_vld = |fl_hit;

   always_comb begin
      res_lo  = '0;
      res_hi  = '0;
      res_cls = '0;
      flag_n  = 1'b0;
      flag_z  = 1'b0;
      for (int i = 0; i < 3; i++) begin
         if (lo_hit[i]) begin
            res_lo  = res_lo | stg_res[i][DW-1:0];
            res_cls = res_cls | stg_kind[i];
         end
         if (hi_hit[i]) res_hi = res_hi | stg_res[i][2*DW-1:DW];
         if (fl_hit[i]) begin
            flag_n = flag_n | stg_n[i];
            flag_z = flag_z | stg_z[i];
         end
      end
   end

endmodule

// File: rtl/mac_seq.sv
module mac_seq
   import mac_seq_pkg::*;
#(
   parameter int DW = 32
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic              set_flags,
   input  logic              long_sel,
   input  logic [DW-1:0]     opa,
   input  logic [DW-1:0]     opb,
   input  logic [2*DW-1:0]   acc,
   output logic              busy,
   output logic              lo_vld,
   output logic [1:0]        res_cls,
   output logic [DW-1:0]     res_lo,
   output logic              hi_vld,
   output logic [DW-1:0]     res_hi,
   output logic              flg_vld,
   output logic              flag_n,
   output logic              flag_z
);

   if (DW < 8 || (DW % 2) != 0) begin : g_bad_dw
      $error("mac_seq: DW must be even and at least 8");
   end

   kind_t         kind;
   logic          lng_eff, flg_eff, accept;
   sched_t        sch_in;
   logic [2:0]    stg_act;
   sched_t [2:0]  stg_sch;
   stg_t  [2:0]   lo_stg, hi_stg, fl_stg;
   kind_t [2:0]   stg_kind;
   logic [2:0][2*DW-1:0] stg_res;
   logic [2:0]    stg_n, stg_z;

   assign kind    = kind_t'(op[1:0]);
   assign lng_eff = long_sel && (kind != K_HMUL);
   assign flg_eff = set_flags && op[1];
   assign sch_in  = make_sched(kind, lng_eff, flg_eff);

   for (genvar i = 0; i < 3; i++) begin : g_split
      assign lo_stg[i]   = stg_sch[i].lo;
      assign hi_stg[i]   = stg_sch[i].hi;
      assign fl_stg[i]   = stg_sch[i].fl;
      assign stg_kind[i] = stg_sch[i].kind;
   end

   mac_seq_ctl u_ctl (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .sch_in  (sch_in),
      .busy    (busy),
      .accept  (accept),
      .stg_act (stg_act),
      .stg_sch (stg_sch)
   );

   mac_seq_dp #(.DW(DW)) u_dp (
      .clk     (clk),
      .rst     (rst),
      .accept  (accept),
      .adv     (stg_act[1:0]),
      .kind    (kind),
      .lng     (lng_eff),
      .sgn     (op[2]),
      .opa     (opa),
      .opb     (opb),
      .acc     (acc),
      .stg_res (stg_res),
      .stg_n   (stg_n),
      .stg_z   (stg_z)
   );

   mac_seq_out #(.DW(DW)) u_out (
      .stg_act  (stg_act),
      .lo_stg   (lo_stg),
      .hi_stg   (hi_stg),
      .fl_stg   (fl_stg),
      .stg_kind (stg_kind),
      .stg_res  (stg_res),
      .stg_n    (stg_n),
      .stg_z    (stg_z),
      .lo_vld   (lo_vld),
      .res_cls  (res_cls),
      .res_lo   (res_lo),
      .hi_vld   (hi_vld),
      .res_hi   (res_hi),
      .flg_vld  (flg_vld),
      .flag_n   (flag_n),
      .flag_z   (flag_z)
   );

endmodule

// File: rtl/mac_seq_chk.sv
module mac_seq_chk
   import mac_seq_pkg::*;
(
   input logic clk,
   input logic rst,
   input logic start,
   input logic busy,
   input logic lo_vld,
   input logic hi_vld,
   input logic flg_vld
);

   logic [PW:0] busy_run;

   always_ff @(posedge clk) begin
      if (rst)       busy_run <= '0;
      else if (busy) busy_run <= busy_run + 1'b1;
      else           busy_run <= '0;
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      $past(rst) |-> (!busy && !lo_vld && !hi_vld && !flg_vld));

   p_accept_r4: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> busy);

   p_busy_bound_r4: assert property (@(posedge clk) disable iff (rst)
      busy_run <= (PW+1)'(MAX_PASS));

   p_hi_after_lo_r6: assert property (@(posedge clk) disable iff (rst)
      hi_vld |-> $past(lo_vld));

   p_flag_after_lo_r9: assert property (@(posedge clk) disable iff (rst)
      flg_vld |-> $past(lo_vld));

endmodule

bind mac_seq mac_seq_chk u_chk (
   .clk     (clk),
   .rst     (rst),
   .start   (start),
   .busy    (busy),
   .lo_vld  (lo_vld),
   .hi_vld  (hi_vld),
   .flg_vld (flg_vld)
);

// File: tb/mac_seq_tb.sv
module mac_seq_tb;

   localparam int TCLK = 10;
   localparam int DW   = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [2:0]    op = '0;
   logic          set_flags = 1'b0;
   logic          long_sel = 1'b0;
   logic [31:0]   opa = '0;
   logic [31:0]   opb = '0;
   logic [63:0]   acc = '0;
   logic          busy, lo_vld, hi_vld, flg_vld, flag_n, flag_z;
   logic [1:0]    res_cls;
   logic [31:0]   res_lo, res_hi;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(TCLK/2) clk = ~clk;

   mac_seq #(.DW(DW)) u_dut (
      .clk(clk), .rst(rst), .start(start), .op(op), .set_flags(set_flags),
      .long_sel(long_sel), .opa(opa), .opb(opb), .acc(acc), .busy(busy),
      .lo_vld(lo_vld), .res_cls(res_cls), .res_lo(res_lo), .hi_vld(hi_vld),
      .res_hi(res_hi), .flg_vld(flg_vld), .flag_n(flag_n), .flag_z(flag_z)
   );

   task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   // schedule per class table: passes and strobe cycles (0 = never)
   function automatic void exp_sched(input logic [2:0] o, input logic f, input logic l,
                                     output int n, output int lc, output int hc,
                                     output int fc, output string tag);
      hc = 0; fc = 0;
      if (o[1:0] == 2'd0) begin n = 1; lc = 3; tag = "R5"; end
      else if (o[1:0] == 2'd1) begin
         n = 2; lc = 3; tag = "R6";
         if (l) hc = 4;
      end else if (!l && !f) begin n = 2; lc = 4; tag = "R7"; end
      else if (l && !f) begin n = 3; lc = 4; hc = 5; tag = "R8"; end
      else if (!l && f) begin n = 4; lc = 4; fc = 5; tag = "R9"; end
      else begin n = 5; lc = 5; hc = 6; fc = 6; tag = "R10"; end
   endfunction

   function automatic logic [63:0] exp_res(input logic [2:0] o, input logic l,
                                           input logic [31:0] a, input logic [31:0] b,
                                           input logic [63:0] c);
      int          hp;
      longint      sa, sb;
      logic [63:0] p;
      logic [31:0] lo;
      hp = int'(shortint'(a[15:0])) * int'(shortint'(b[15:0]));
      if (o[1:0] == 2'd0) return {32'h0, hp};
      if (o[1:0] == 2'd1) begin
         if (l) return 64'(longint'(hp)) + c;
         lo = hp + c[31:0];
         return {32'h0, lo};
      end
      sa = $signed(a);
      sb = $signed(b);
      p  = o[2] ? 64'(sa * sb) : ({32'h0, a} * {32'h0, b});
      if (o[0]) begin
         if (l) p = p + c;
         else   p = {32'h0, p[31:0] + c[31:0]};
      end else if (!l) begin
         p = {32'h0, p[31:0]};
      end
      return p;
   endfunction

   task automatic run_op(input logic [2:0] o, input logic f, input logic l,
                         input logic [31:0] a, input logic [31:0] b, input logic [63:0] c);
      int n, lc, hc, fc;
      string tag;
      logic [63:0] r;
      logic l_eff;
      logic en, ez;
      l_eff = l && (o[1:0] != 2'd0);
      exp_sched(o, f && o[1], l_eff, n, lc, hc, fc, tag);
      r  = exp_res(o, l_eff, a, b, c);
      en = l_eff ? r[63] : r[31];
      ez = l_eff ? (r == 64'h0) : (r[31:0] == 32'h0);
      @(negedge clk);
      start = 1'b1; op = o; set_flags = f; long_sel = l;
      opa = a; opb = b; acc = c;
      @(posedge clk);
      for (int cyc = 1; cyc <= 8; cyc++) begin
         @(negedge clk);
         chk(busy == (cyc <= n), "R4", $sformatf("busy cyc%0d", cyc), 64'(busy), 64'(cyc <= n));
         chk(lo_vld == (cyc == lc), tag, $sformatf("lo_vld cyc%0d", cyc), 64'(lo_vld), 64'(cyc == lc));
         chk(hi_vld == (cyc == hc), tag, $sformatf("hi_vld cyc%0d", cyc), 64'(hi_vld), 64'(cyc == hc));
         chk(flg_vld == (cyc == fc), (fc == 0) ? "R11" : tag,
             $sformatf("flg_vld cyc%0d", cyc), 64'(flg_vld), 64'(cyc == fc));
         if (cyc == lc) begin
            chk(res_lo == r[31:0], (o[1]) ? "R3" : "R2", "res_lo", 64'(res_lo), 64'(r[31:0]));
            chk(res_cls == o[1:0], "R12", "res_cls", 64'(res_cls), 64'(o[1:0]));
         end
         if (cyc == hc)
            chk(res_hi == r[63:32], (o[1]) ? "R3" : "R2", "res_hi", 64'(res_hi), 64'(r[63:32]));
         if (cyc == fc)
            chk({flag_n, flag_z} == {en, ez}, "R11", "flags", 64'({flag_n, flag_z}), 64'({en, ez}));
         // junk issue while busy must be ignored (R4)
         if (cyc < n) begin
            start = 1'b1; op = 3'($urandom); set_flags = 1'($urandom);
            long_sel = 1'($urandom); opa = $urandom; opb = $urandom;
            acc = {$urandom, $urandom};
         end else begin
            start = 1'b0;
         end
      end
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      chk(!busy && !lo_vld && !hi_vld && !flg_vld, "R1", "outputs in reset",
          64'({busy, lo_vld, hi_vld, flg_vld}), 64'h0);
      rst = 1'b0;
      @(negedge clk);
      chk(!busy && !lo_vld && !hi_vld && !flg_vld, "R1", "outputs after reset",
          64'({busy, lo_vld, hi_vld, flg_vld}), 64'h0);

      // directed corners
      run_op(3'd0, 1'b1, 1'b1, 32'h0000_8000, 32'h0000_7fff, 64'h0);          // R5 ignores flags/long
      run_op(3'd1, 1'b1, 1'b0, 32'h0000_ffff, 32'h0000_0001, 64'h1);          // R6 zero, no flags R11
      run_op(3'd1, 1'b0, 1'b1, 32'h0000_8000, 32'h0000_0002, 64'h5);          // R6 long negative
      run_op(3'd2, 1'b0, 1'b0, 32'hffff_ffff, 32'hffff_ffff, 64'h0);          // R7
      run_op(3'd6, 1'b0, 1'b1, 32'hffff_ffff, 32'h0000_0002, 64'h0);          // R8 signed
      run_op(3'd2, 1'b0, 1'b1, 32'hffff_ffff, 32'h0000_0002, 64'h0);          // R8 unsigned
      run_op(3'd3, 1'b1, 1'b0, 32'h0000_0000, 32'h1234_5678, 64'h0);          // R9 zero flag
      run_op(3'd7, 1'b1, 1'b1, 32'h8000_0000, 32'h0000_0001, 64'h0);          // R10 negative
      run_op(3'd7, 1'b1, 1'b1, 32'h0000_0000, 32'h0000_0000, 64'h0);          // R10 zero

      for (int k = 0; k < 300; k++) begin
         logic [31:0] a, b;
         a = $urandom;
         b = $urandom;
         if (($urandom % 8) == 0) a = '0;
         run_op(3'($urandom), 1'($urandom), 1'($urandom), a, b, {$urandom, $urandom});
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(TCLK * 150000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=%h exp=%h", 64'h0, 64'h1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule